// File: doc/BRIEF.md
# LSB-Justified Audio Serial Port (Slave)

This block is a slave audio serial port that moves one sample per channel slot between a serial data pair and a 16-bit host data register. Bit clock and word select come from an external master. Each channel slot is 32 bit-clock periods long and is sent MSB first. The significant bits sit at the end of the slot, so the padding bits come first. The block inserts the padding on transmit and strips it on receive, so the host only ever handles significant data.

Two packings are available. In the first, a 16-bit sample fills the low half of the slot, and the host makes one register access per sample. In the second, a 24-bit sample fills the low three bytes, and the host makes two half-word accesses: the upper byte first, then the low 16 bits. The empty and full flags change state when the significant part of a slot begins or ends, not at slot boundaries. This gives the host most of a slot in which to respond. Underrun and overrun are flagged and stay set until the port is disabled.

All serial inputs are resynchronised to the system clock. The bit clock must therefore be well below the system clock: each phase of the bit clock must last at least four system cycles.

Top module: `i2s_lsbj_port`

## Requirements
- R1: When `pack24`=0, each slot carries 16 zero bits followed by the 16-bit sample, MSB first. `sd_out` takes each new bit after a falling edge of `ck`.
- R2: `txe`=1 means the transmit register can take data. A write sets `txe` to 0 once the whole sample is present. `txe` returns to 1 when the last bit of the slot (bit index 31) is driven. A write made while `txe`=0 is ignored.
- R3: If the transmit register is not full when the first significant bit of a slot is due (index 16, or index 8 when `pack24`=1), that slot sends only zeros and `underrun` is set. A partly written 24-bit sample is discarded. `underrun` stays set until the port is disabled.
- R4: `sd_in` is sampled on each rising edge of `ck`. When `pack24`=0, the last 16 bits of the slot become the received word. `rxne` goes high only after the slot's final bit (index 31) has been captured, never during the leading field. A read made while `rxne`=1 clears `rxne`. A read made while `rxne`=0 has no effect.
- R5: If a slot completes while `rxne` is still 1, `overrun` is set, the new sample is discarded and the stored word is kept.
- R6: When `pack24`=1, a received sample is read in two steps. The first read returns 0x00 followed by bits 23:16 of the sample: the top byte is forced to zero whatever was on the line. The second read returns bits 15:0 and clears `rxne`. For example, 0x3478AE reads as 0x0034, then 0x78AE.
- R7: When `pack24`=1, the first write supplies the upper byte of the sample (only `host_wdata[7:0]` is used) and the second write supplies the low 16 bits. The slot then sends 8 zeros followed by the 24 bits. `pack24` may change only while `en`=0.
- R8: `chside` gives the channel of the word in the receive register: 0 for a slot sent while `ws` was low (left), 1 for a slot sent while `ws` was high (right).
- R9: A change of `ws` seen at a falling edge of `ck` marks bit 0 of a new slot. After enabling, nothing is sent or received until the first such change.
- R10: While `en`=0, `sd_out` is 0, `txe`=1, `rxne`=0, and `underrun` and `overrun` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low clears all state |
| pack24 | input | 1 | 0: 16-bit sample in a 32-bit slot; 1: 24-bit sample in a 32-bit slot |
| ck | input | 1 | Serial bit clock from the master |
| ws | input | 1 | Word select from the master (0 left, 1 right) |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| host_wr | input | 1 | One-cycle write strobe for the transmit register |
| host_wdata | input | 16 | Transmit write data |
| host_rd | input | 1 | One-cycle read strobe for the receive register |
| host_rdata | output | 16 | Receive data currently presented |
| txe | output | 1 | Transmit register can take data |
| rxne | output | 1 | Receive register holds unread data |
| chside | output | 1 | Channel of the received word |
| underrun | output | 1 | Sticky transmit underrun |
| overrun | output | 1 | Sticky receive overrun |

## Verification
The bench goes after the points where the empty and full flags change. A design that raised `txe` at the slot boundary instead of at the last driven bit would fail the per-bit flag compare. A design that set `rxne` during the zero field would also fail it, well before any read takes place. Samples are chosen with nonzero leading fields and a nonzero byte above the 24-bit sample, so that a design which passed line bits into the padded part of a word would return a wrong read value. Underrun is exercised both with no write at all and with only the first of two 24-bit writes. Overrun is checked by reading the stored word after a second slot has arrived, and a design that kept the newer sample would return the wrong value.

// File: rtl/i2s_lsbj_pkg.sv
package i2s_lsbj_pkg;

  localparam int SLOT_BITS = 32;
  localparam int HALF_BITS = 16;
  localparam int WIDE_BITS = 24;
  localparam int BYTE_BITS = WIDE_BITS - HALF_BITS;
  localparam int IDX_W     = $clog2(SLOT_BITS);

  typedef enum logic {
    PACK_16X32 = 1'b0,
    PACK_24X32 = 1'b1
  } pack_e;

  // index of the first significant bit inside a slot
  function automatic logic [IDX_W-1:0] sig_first(input pack_e p);
    return (p == PACK_24X32) ? IDX_W'(SLOT_BITS - WIDE_BITS)
                             : IDX_W'(SLOT_BITS - HALF_BITS);
  endfunction

  // index of the final bit of a slot
  function automatic logic [IDX_W-1:0] slot_last();
    return IDX_W'(SLOT_BITS - 1);
  endfunction

  // bit of a slot word driven at a given index (MSB first)
  function automatic logic slot_bit(input logic [SLOT_BITS-1:0] w,
                                    input logic [IDX_W-1:0] idx);
    return w[slot_last() - idx];
  endfunction

  // slot word assembled from the held transmit parts
  function automatic logic [SLOT_BITS-1:0] tx_word(input pack_e p,
                                                   input logic [BYTE_BITS-1:0] hi,
                                                   input logic [HALF_BITS-1:0] lo);
    if (p == PACK_24X32)
      return {{(SLOT_BITS-WIDE_BITS){1'b0}}, hi, lo};
    return {{(SLOT_BITS-HALF_BITS){1'b0}}, lo};
  endfunction

  // first half-word of a 24-bit sample: upper byte forced to zero
  function automatic logic [HALF_BITS-1:0] rx_upper(input logic [BYTE_BITS-1:0] hi);
    return HALF_BITS'(hi);
  endfunction

endpackage

// File: rtl/i2s_lsbj_insync.sv
module i2s_lsbj_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ck_raw,
  input  logic ws_raw,
  input  logic sd_raw,
  output logic ck_rise,
  output logic ck_fall,
  output logic ws_s,
  output logic sd_s
);

  localparam int LINES = 3;

  logic [LINES-1:0] chain_q [STAGES];
  logic             ck_last_q;
  logic             ck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      ck_last_q <= 1'b0;
    end else begin
      chain_q[0] <= {ck_raw, ws_raw, sd_raw};
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      ck_last_q <= ck_s;
    end
  end

  assign ck_s    = chain_q[STAGES-1][2];
  assign ws_s    = chain_q[STAGES-1][1];
  assign sd_s    = chain_q[STAGES-1][0];
  assign ck_rise = ck_s & ~ck_last_q;
  assign ck_fall = ~ck_s & ck_last_q;

endmodule

// File: rtl/i2s_lsbj_framer.sv
module i2s_lsbj_framer
  import i2s_lsbj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ck_fall,
  input  logic             ws_s,
  output logic             drive_ev,
  output logic [IDX_W-1:0] drive_idx,
  output logic             framed,
  output logic [IDX_W-1:0] bit_idx,
  output logic             chan
);

  logic ws_last_q;
  logic ws_edge;

  assign ws_edge   = ws_s ^ ws_last_q;
  assign drive_ev  = en & ck_fall & (framed | ws_edge);
  assign drive_idx = ws_edge ? '0 : bit_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_last_q <= 1'b0;
      framed    <= 1'b0;
      bit_idx   <= '0;
      chan      <= 1'b0;
    end else if (!en) begin
      ws_last_q <= ws_s;
      framed    <= 1'b0;
      bit_idx   <= '0;
    end else if (ck_fall) begin
      ws_last_q <= ws_s;
      if (drive_ev) begin
        framed  <= 1'b1;
        bit_idx <= drive_idx;
        if (ws_edge) chan <= ws_s;
      end
    end
  end

endmodule

// File: rtl/i2s_lsbj_tx.sv
module i2s_lsbj_tx
  import i2s_lsbj_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  pack_e                pack,
  input  logic                 wr,
  input  logic [HALF_BITS-1:0] wdata,
  input  logic                 drive_ev,
  input  logic [IDX_W-1:0]     drive_idx,
  output logic                 sd_out,
  output logic                 txe,
  output logic                 underrun
);

  logic                 full_q;
  logic                 half_q;
  logic                 live_q;
  logic [BYTE_BITS-1:0] hi_q;
  logic [HALF_BITS-1:0] lo_q;
  logic [IDX_W-1:0]     first_idx;
  logic                 at_first;
  logic                 in_pad;
  logic                 at_last;
  logic [SLOT_BITS-1:0] word;

  assign first_idx = sig_first(pack);
  assign at_first  = drive_ev && (drive_idx == first_idx);
  assign in_pad    = drive_idx < first_idx;
  assign at_last   = drive_ev && (drive_idx == slot_last());
  assign word      = tx_word(pack, hi_q, lo_q);
  assign txe       = ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      half_q   <= 1'b0;
      live_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      sd_out   <= 1'b0;
      underrun <= 1'b0;
    end else if (!en) begin
      full_q   <= 1'b0;
      half_q   <= 1'b0;
      live_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      sd_out   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (drive_ev) begin
        if (at_first) begin
          live_q <= full_q;
          sd_out <= full_q ? slot_bit(word, drive_idx) : 1'b0;
          if (!full_q) begin
            underrun <= 1'b1;
            half_q   <= 1'b0;
          end
        end else if (in_pad) begin
          sd_out <= 1'b0;
        end else begin
          sd_out <= live_q ? slot_bit(word, drive_idx) : 1'b0;
        end
        if (at_last && live_q) begin
          full_q <= 1'b0;
          live_q <= 1'b0;
        end
      end
      if (wr && !full_q) begin
        if (pack == PACK_24X32 && !half_q) begin
          hi_q   <= wdata[BYTE_BITS-1:0];
          half_q <= 1'b1;
        end else begin
          lo_q   <= wdata;
          full_q <= 1'b1;
          half_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/i2s_lsbj_rx.sv
module i2s_lsbj_rx
  import i2s_lsbj_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  pack_e                pack,
  input  logic                 rd,
  input  logic                 rise_ev,
  input  logic                 framed,
  input  logic [IDX_W-1:0]     bit_idx,
  input  logic                 chan,
  input  logic                 sd_s,
  output logic [HALF_BITS-1:0] rdata,
  output logic                 rxne,
  output logic                 overrun,
  output logic                 chside,
  output logic                 rd_half
);

  logic [WIDE_BITS-2:0] shift_q;
  logic [WIDE_BITS-1:0] sample;
  logic                 take;
  logic                 done;
  logic [BYTE_BITS-1:0] hi_q;
  logic [HALF_BITS-1:0] lo_q;

  assign take   = en && rise_ev && framed;
  assign done   = take && (bit_idx == slot_last());
  assign sample = {shift_q, sd_s};
  assign rdata  = (pack == PACK_24X32 && !rd_half) ? rx_upper(hi_q) : lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      rxne    <= 1'b0;
      overrun <= 1'b0;
      chside  <= 1'b0;
      rd_half <= 1'b0;
    end else if (!en) begin
      shift_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      rxne    <= 1'b0;
      overrun <= 1'b0;
      chside  <= 1'b0;
      rd_half <= 1'b0;
    end else begin
      if (take) shift_q <= sample[WIDE_BITS-2:0];
      if (rd && rxne) begin
        if (pack == PACK_24X32 && !rd_half) begin
          rd_half <= 1'b1;
        end else begin
          rxne    <= 1'b0;
          rd_half <= 1'b0;
        end
      end
      if (done) begin
        if (rxne) begin
          overrun <= 1'b1;
        end else begin
          hi_q    <= sample[WIDE_BITS-1:HALF_BITS];
          lo_q    <= sample[HALF_BITS-1:0];
          chside  <= chan;
          rxne    <= 1'b1;
          rd_half <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/i2s_lsbj_port.sv
module i2s_lsbj_port
  import i2s_lsbj_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 pack24,
  input  logic                 ck,
  input  logic                 ws,
  input  logic                 sd_in,
  output logic                 sd_out,
  input  logic                 host_wr,
  input  logic [HALF_BITS-1:0] host_wdata,
  input  logic                 host_rd,
  output logic [HALF_BITS-1:0] host_rdata,
  output logic                 txe,
  output logic                 rxne,
  output logic                 chside,
  output logic                 underrun,
  output logic                 overrun
);

  // internal events brought out for the checker
  logic             rise_ev;
  logic             fall_ev;
  logic             ws_s;
  logic             sd_s;
  logic             drive_ev;
  logic [IDX_W-1:0] drive_idx;
  logic             framed;
  logic [IDX_W-1:0] bit_idx;
  logic             chan;
  logic             rd_half;
  pack_e            pack;

  assign pack = pack_e'(pack24);

  i2s_lsbj_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .ck_raw(ck), .ws_raw(ws), .sd_raw(sd_in),
    .ck_rise(rise_ev), .ck_fall(fall_ev), .ws_s(ws_s), .sd_s(sd_s)
  );

  i2s_lsbj_framer u_frame (
    .clk(clk), .rst_n(rst_n), .en(en),
    .ck_fall(fall_ev), .ws_s(ws_s),
    .drive_ev(drive_ev), .drive_idx(drive_idx),
    .framed(framed), .bit_idx(bit_idx), .chan(chan)
  );

  i2s_lsbj_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .pack(pack),
    .wr(host_wr), .wdata(host_wdata),
    .drive_ev(drive_ev), .drive_idx(drive_idx),
    .sd_out(sd_out), .txe(txe), .underrun(underrun)
  );

  i2s_lsbj_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .pack(pack),
    .rd(host_rd), .rise_ev(rise_ev), .framed(framed),
    .bit_idx(bit_idx), .chan(chan), .sd_s(sd_s),
    .rdata(host_rdata), .rxne(rxne), .overrun(overrun),
    .chside(chside), .rd_half(rd_half)
  );

endmodule

// File: rtl/i2s_lsbj_port_chk.sv
module i2s_lsbj_port_chk
  import i2s_lsbj_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 pack24,
  input logic                 sd_out,
  input logic                 txe,
  input logic                 rxne,
  input logic                 underrun,
  input logic                 host_rd,
  input logic [HALF_BITS-1:0] host_rdata,
  input logic                 drive_ev,
  input logic                 rise_ev,
  input logic                 rd_half,
  input logic [IDX_W-1:0]     bit_idx
);

  assert_sd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> !sd_out);

  assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drive_ev) && bit_idx < sig_first(pack_e'(pack24))) |-> !sd_out);

  assert_txe_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $rose(txe)) |-> bit_idx == slot_last());

  assert_underrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(underrun)) |-> underrun);

  assert_rxne_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> ($past(rise_ev) && bit_idx == slot_last()));

  assert_old_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(rxne) && rxne && !$past(host_rd)) |-> $stable(host_rdata));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rxne && pack24 && !rd_half) |-> host_rdata[HALF_BITS-1:BYTE_BITS] == '0);

  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(pack24));

endmodule

bind i2s_lsbj_port i2s_lsbj_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pack24(pack24),
  .sd_out(sd_out), .txe(txe), .rxne(rxne), .underrun(underrun),
  .host_rd(host_rd), .host_rdata(host_rdata),
  .drive_ev(drive_ev), .rise_ev(rise_ev), .rd_half(rd_half),
  .bit_idx(bit_idx)
);

// File: tb/i2s_lsbj_port_tb_top.sv
module i2s_lsbj_port_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pack24 = 1'b0;
  logic ck = 1'b1, ws = 1'b1, sd_in = 1'b0;
  logic sd_out;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic txe, rxne, chside, underrun, overrun;

  always #4 clk = ~clk;

  i2s_lsbj_port dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pack24(pack24),
    .ck(ck), .ws(ws), .sd_in(sd_in), .sd_out(sd_out),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .txe(txe), .rxne(rxne), .chside(chside),
    .underrun(underrun), .overrun(overrun)
  );

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  // behavioural reference state
  logic       m_full, m_half, m_live, m_under, m_over;
  logic       m_rxne, m_rhalf, m_rch;
  logic [7:0]  m_hi, m_rhi;
  logic [15:0] m_lo, m_rlo;
  logic       cur_ch;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_full = 0; m_half = 0; m_live = 0; m_under = 0; m_over = 0;
    m_rxne = 0; m_rhalf = 0; m_hi = 0; m_lo = 0;
  endtask

  task automatic slot(input logic [31:0] rxw, input string tag);
    logic [31:0] txw;
    int first;
    logic exp_bit;
    first = pack24 ? 8 : 16;
    txw = pack24 ? {8'h00, m_hi, m_lo} : {16'h0000, m_lo};
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ck = 1'b0;
      if (i == 0) ws = cur_ch;
      sd_in = rxw[31-i];
      exp_bit = 1'b0;
      if (en) begin
        if (i == first) begin
          m_live = m_full;
          if (!m_full) begin m_under = 1; m_half = 0; end
        end
        if (i >= first && m_live) exp_bit = txw[31-i];
        if (i == 31 && m_live) begin m_full = 0; m_live = 0; end
      end
      repeat (HALF-1) @(negedge clk);
      chk({tag, " sd_out"}, 32'(sd_out), 32'(exp_bit));
      chk("R2 txe", 32'(txe), 32'(!m_full));
      chk("R4 rxne low phase", 32'(rxne), 32'(m_rxne));
      @(negedge clk);
      ck = 1'b1;
      if (en && i == 31) begin
        if (m_rxne) m_over = 1;
        else begin
          m_rxne = 1; m_rhalf = 0; m_rhi = rxw[23:16]; m_rlo = rxw[15:0]; m_rch = cur_ch;
        end
      end
      repeat (HALF-1) @(negedge clk);
      chk("R4 rxne high phase", 32'(rxne), 32'(m_rxne));
      chk("R5 overrun", 32'(overrun), 32'(m_over));
      chk("R3 underrun", 32'(underrun), 32'(m_under));
    end
    cur_ch = ~cur_ch;
  endtask

  task automatic host_write(input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = d;
    if (!m_full) begin
      if (pack24 && !m_half) begin m_hi = d[7:0]; m_half = 1; end
      else begin m_lo = d; m_full = 1; m_half = 0; end
    end
    @(negedge clk);
    host_wr = 1'b0;
    chk("R2 txe after write", 32'(txe), 32'(!m_full));
  endtask

  task automatic host_read();
    @(negedge clk);
    chk("R4 rxne before read", 32'(rxne), 32'(m_rxne));
    if (m_rxne) begin
      if (pack24 && !m_rhalf) chk("R6 upper read", 32'(host_rdata), {24'h0, m_rhi});
      else chk(pack24 ? "R6 lower read" : "R4 read", 32'(host_rdata), 32'(m_rlo));
      chk("R8 chside", 32'(chside), 32'(m_rch));
    end
    host_rd = 1'b1;
    if (m_rxne) begin
      if (pack24 && !m_rhalf) m_rhalf = 1;
      else begin m_rxne = 0; m_rhalf = 0; end
    end
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    chk("R4 rxne after read", 32'(rxne), 32'(m_rxne));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    cur_ch = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset txe", 32'(txe), 32'd1);
    chk("R10 reset rxne", 32'(rxne), 32'd0);
    chk("R10 reset flags", {30'd0, underrun, overrun}, 32'd0);
    chk("R10 reset sd_out", 32'(sd_out), 32'd0);

    // 16-bit packing
    en = 1'b1;
    repeat (4) @(negedge clk);
    slot(32'hDEAD_1234, "R9");          // no data written: underrun
    host_read();
    host_write(16'h76A3);
    host_write(16'h1111);               // R2: ignored while full
    slot(32'h0000_ABCD, "R1");
    host_read();
    host_write(16'h8001);
    slot(32'hFFFF_2222, "R1");
    host_write(16'h0FF0);
    slot(32'h0000_4444, "R1");          // R5: overrun, 0x2222 kept
    host_read();
    host_read();                         // R4: read while empty ignored
    host_write(16'hC3C3);
    slot(32'h5555_0F0F, "R1");
    host_read();

    // disable, switch packing
    @(negedge clk);
    en = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    chk("R10 disable flags", {29'd0, rxne, underrun, overrun}, 32'd0);
    chk("R10 disable txe", 32'(txe), 32'd1);
    slot(32'hFFFF_FFFF, "R10");
    pack24 = 1'b1;
    @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);

    // 24-bit packing
    host_write(16'hFF12);
    host_write(16'h3456);
    slot(32'hA534_78AE, "R9");
    host_read();
    host_read();
    host_write(16'h00AB);
    host_write(16'hCDEF);
    slot(32'hFF80_0001, "R7");
    host_read();
    host_read();
    host_write(16'h0077);               // only half written: underrun next
    slot(32'h1234_5678, "R7");
    slot(32'h9ABC_DEF0, "R7");          // overrun, 0x345678 kept
    host_read();
    host_read();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule